// File: doc/BRIEF.md
# Shared-Hysteresis Bimodal Branch Predictor

This block is the base direction predictor of a branch prediction unit. It is a table of one-bit direction predictions, addressed by a branch index that the surrounding logic has already computed. Each entry has its own prediction bit. The confidence bit (hysteresis) is stored more sparsely: one hysteresis bit serves a group of `2^GRP_LOG` neighbouring entries. The group of an entry is its index shifted right by `GRP_LOG` bits.

A lookup port returns the stored prediction bit for an index combinationally. An update port takes an index and the resolved outcome of the branch. The update joins the entry's prediction bit (upper bit) with its group's hysteresis bit (lower bit) into a two-bit saturating counter. It steps the counter once and writes both bits back. An update therefore changes the direction of one entry but the confidence of the whole group. The table holds `2^IDX_BITS` entries.

Top module: `bimodal_shyst_pred`

## Requirements
- R1: While `rst_n` is low, and from then until the first update, every prediction bit is 0 (not taken) and every hysteresis bit is 1. A fresh entry therefore predicts not taken, and a single taken update flips it to taken.
- R2: `lkp_taken` equals the prediction bit of entry `lkp_idx` in the same cycle. The hysteresis bit plays no part in it.
- R3: On an update with `upd_taken`=1, the counter {prediction bit of `upd_idx`, hysteresis bit of group `upd_idx>>GRP_LOG`} is incremented by one. A counter of 3 stays at 3.
- R4: On an update with `upd_taken`=0, the counter is decremented by one. A counter of 0 stays at 0.
- R5: After an update, the new upper counter bit is the prediction bit of `upd_idx`, and the new lower bit is the hysteresis bit of its group. No other entry's prediction bit changes.
- R6: Entries whose indices are equal after a right shift by `GRP_LOG` share one hysteresis bit. An update to one entry changes the confidence used by the next update to any entry of that group.
- R7: An update takes effect at the next rising clock edge. A lookup of the updated index in the update cycle returns the old value. An update in the following cycle reads the state written by the previous one.
- R8: When `upd_en` is 0, no prediction or hysteresis bit changes, whatever `upd_idx` and `upd_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_idx | input | IDX_BITS | Index of the entry to look up |
| lkp_taken | output | 1 | Predicted direction of `lkp_idx` (1 = taken) |
| upd_en | input | 1 | Apply an update this cycle |
| upd_idx | input | IDX_BITS | Index of the entry to update |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The assertions assume that `upd_idx` and `upd_taken` carry known values whenever `upd_en` is high. They also assume that reset is asserted from time zero, so that the state is defined before the first check. The bench drives every input at the falling edge, from pseudo-random sequences that are always defined, and holds reset from the first instant. The stimulus uses a small table of sixteen entries in groups of four, so that sequences of updates often hit neighbours of one group in consecutive cycles. The bench also sweeps the counter through both saturation points.

// File: rtl/bimodal_shyst_pred.sv
module bimodal_shyst_pred #(
  parameter int IDX_BITS = 10,
  parameter int GRP_LOG  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_BITS-1:0] lkp_idx,
  output logic                lkp_taken,
  input  logic                upd_en,
  input  logic [IDX_BITS-1:0] upd_idx,
  input  logic                upd_taken
);
  localparam int NENT = 1 << IDX_BITS;
  localparam int NGRP = 1 << (IDX_BITS - GRP_LOG);
  localparam int GW   = (IDX_BITS > GRP_LOG) ? IDX_BITS - GRP_LOG : 1;

  logic [NENT-1:0] pred_q;
  logic [NGRP-1:0] hyst_q;
  logic [GW-1:0]   upd_grp;
  logic [1:0]      ctr_old;
  logic [1:0]      ctr_new;

  assign upd_grp = GW'(upd_idx >> GRP_LOG);
  assign ctr_old = {pred_q[upd_idx], hyst_q[upd_grp]};

  always_comb begin
    if (upd_taken) ctr_new = (ctr_old == 2'd3) ? ctr_old : 2'(ctr_old + 2'd1);
    else           ctr_new = (ctr_old == 2'd0) ? ctr_old : 2'(ctr_old - 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      hyst_q <= '1;
    end else if (upd_en) begin
      pred_q[upd_idx] <= ctr_new[1];
      hyst_q[upd_grp] <= ctr_new[0];
    end
  end

  assign lkp_taken = pred_q[lkp_idx];
endmodule

// File: rtl/bimodal_shyst_pred_chk.sv
module bimodal_shyst_pred_chk #(
  parameter int IDX_BITS = 10,
  parameter int GRP_LOG  = 2
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 upd_en,
  input logic [IDX_BITS-1:0]                  upd_idx,
  input logic                                 upd_taken,
  input logic [(1<<IDX_BITS)-1:0]             pred_q,
  input logic [(1<<(IDX_BITS-GRP_LOG))-1:0]   hyst_q
);
  localparam int GW = (IDX_BITS > GRP_LOG) ? IDX_BITS - GRP_LOG : 1;
  logic [GW-1:0] grp;
  assign grp = GW'(upd_idx >> GRP_LOG);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pred_q == '0) && (&hyst_q)); // R1

  AST_TAKEN_KEEPS_STRONG: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_taken && pred_q[upd_idx]
    |=> pred_q[$past(upd_idx)] && hyst_q[$past(grp)]); // R3

  AST_TAKEN_FROM_WEAK_NT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_taken && !pred_q[upd_idx] && hyst_q[grp]
    |=> pred_q[$past(upd_idx)] && !hyst_q[$past(grp)]); // R3

  AST_NOT_TAKEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !upd_taken && !pred_q[upd_idx]
    |=> !pred_q[$past(upd_idx)] && !hyst_q[$past(grp)]); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(pred_q) && $stable(hyst_q)); // R8

  AST_ONE_PRED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> $countones(pred_q ^ $past(pred_q)) <= 1); // R5
endmodule

bind bimodal_shyst_pred bimodal_shyst_pred_chk #(
  .IDX_BITS(IDX_BITS), .GRP_LOG(GRP_LOG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_idx(upd_idx),
  .upd_taken(upd_taken), .pred_q(pred_q), .hyst_q(hyst_q)
);

// File: tb/test_bimodal_shyst_pred.sv
`timescale 1ns/1ps
module test_bimodal_shyst_pred;
  localparam int L = 4;
  localparam int R = 2;
  localparam int N = 1 << L;
  localparam int G = 1 << (L - R);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0] lkp_idx = '0;
  logic lkp_taken;
  logic upd_en = 1'b0;
  logic [L-1:0] upd_idx = '0;
  logic upd_taken = 1'b0;

  int checks = 0;
  int failures = 0;
  bit mp [N];
  bit mh [G];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  bimodal_shyst_pred #(.IDX_BITS(L), .GRP_LOG(R)) i_bimodal_shyst_pred (
    .clk(clk), .rst_n(rst_n), .lkp_idx(lkp_idx), .lkp_taken(lkp_taken),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_taken(upd_taken));

  task automatic chk(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: lkp_taken=%0b expected=%0b (lkp_idx=%0d)", req, act, exp, lkp_idx);
    end
  endtask

  task automatic model_upd(int idx, bit t);
    int c;
    c = {mp[idx], mh[idx >> R]};
    if (t) c = (c == 3) ? 3 : c + 1;
    else   c = (c == 0) ? 0 : c - 1;
    mp[idx] = c[1];
    mh[idx >> R] = c[0];
  endtask

  // one cycle: drive at negedge, check the lookup before the edge, then advance the model
  task automatic cyc(bit en, int ui, bit ut, int li, string req);
    @(negedge clk);
    upd_en = en; upd_idx = L'(ui); upd_taken = ut; lkp_idx = L'(li);
    #1 chk(req, lkp_taken, mp[li]);
    @(posedge clk);
    if (en) model_upd(ui, ut);
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < N; i++) cyc(1'b0, 0, 1'b1, i, req);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    for (int i = 0; i < N; i++) mp[i] = 1'b0;
    for (int i = 0; i < G; i++) mh[i] = 1'b1;
    repeat (3) @(posedge clk);
    // lookups during reset: all not taken
    @(negedge clk); lkp_idx = 4'd9; #1 chk("R1", lkp_taken, 1'b0);
    rst_n = 1'b1;
    sweep("R1");
    // R8: updates with enable low leave every entry alone
    for (int i = 0; i < N; i++) cyc(1'b0, i, 1'b1, (i + 1) % N, "R8");
    sweep("R8");
    // R1/R7: first taken flips entry 0; same-cycle lookup sees old value
    cyc(1'b1, 0, 1'b1, 0, "R7");
    cyc(1'b0, 0, 1'b0, 0, "R1");
    if (mp[0] !== 1'b1) $display("FAIL R1: model pred0=%0b expected=1", mp[0]);
    // R6: neighbour in the same group sees the cleared hysteresis, stays not taken
    cyc(1'b1, 1, 1'b1, 1, "R7");
    cyc(1'b0, 0, 1'b0, 1, "R6");
    cyc(1'b1, 1, 1'b1, 2, "R6");
    cyc(1'b0, 0, 1'b0, 1, "R6");
    // R3 saturation at 3, then one not-taken keeps taken
    for (int k = 0; k < 5; k++) cyc(1'b1, 5, 1'b1, 5, "R3");
    cyc(1'b1, 5, 1'b0, 5, "R3");
    cyc(1'b0, 0, 1'b0, 5, "R3");
    // R4 saturation at 0, then one taken still predicts not taken
    for (int k = 0; k < 5; k++) cyc(1'b1, 6, 1'b0, 6, "R4");
    cyc(1'b1, 6, 1'b1, 6, "R4");
    cyc(1'b0, 0, 1'b0, 6, "R4");
    sweep("R5");
    // R7: back-to-back updates within one group
    for (int k = 0; k < 64; k++) begin
      step_lfsr();
      cyc(1'b1, {2'b10, lfsr[1:0]}, lfsr[4], {2'b10, lfsr[3:2]}, "R7");
    end
    sweep("R6");
    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      step_lfsr();
      cyc(lfsr[9] | lfsr[2], int'(lfsr[3:0]), lfsr[8], int'(lfsr[7:4]), "R2");
    end
    sweep("R5");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule